// File: doc/BRIEF.md
# Gray-Coded Up-Counter with Parallel Load

This block is a synchronous up-counter whose state register holds its value in reflected-binary Gray code at all times. Each enabled clock edge advances the count to the next code of the sequence, so only one output bit changes per step. This keeps switching activity low and makes the count safe to sample while it moves. A load strobe replaces the state with a Gray-coded value from a data bus.

The width is a parameter, and the block is used at 4 and at 8 bits. A second parameter chooses how the next code is formed. The first choice converts the code to binary, adds one and converts back. The second choice works out directly in the Gray domain which single bit to flip. Both choices give the same sequence.

Top module: `gray_counter`

## Requirements
- R1: While `rst_ni` is low the count is cleared to all zeros, without waiting for a clock edge.
- R2: With `en_i` high and `load_i` low, each rising edge moves `count_o` from the Gray code of binary value b to the Gray code of b+1 (modulo 2^WIDTH), where the Gray code of b is b ^ (b >> 1).
- R3: An enabled increment changes exactly one bit of `count_o`.
- R4: With `en_i` low and `load_i` low, `count_o` keeps its value across an edge.
- R5: With `load_i` high, `count_o` equals `load_data_i` after the next rising edge, stored without any code conversion.
- R6: When `load_i` and `en_i` are both high, the load wins and no increment is applied.
- R7: From the last code (MSB set, every other bit clear), an enabled edge wraps the count to all zeros.
- R8: At WIDTH=4 the step from decimal 7 to 8 moves `count_o` from 0100 to 1100.
- R9: The `NEXT_STYLE` parameter picks a convert-and-add or a direct bit-flip next-state circuit, and both follow the same sequence at WIDTH=4 and WIDTH=8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| load_i | input | 1 | Parallel-load strobe |
| load_data_i | input | WIDTH | Gray-coded value to load |
| count_o | output | WIDTH | Gray-coded count |

## Verification
Load and enable can be asserted in the same cycle. The bench drives both high together, with load data that differs from the incremented code, and expects the loaded value with no step on top of it. A one-bit-change check is not applied to that cycle. Loads are also placed right before the wrap code, so an increment that follows a load is judged against the loaded value rather than the old count.

// File: rtl/gray_cnt_pkg.sv
package gray_cnt_pkg;
  typedef enum logic {
    NEXT_CONVERT = 1'b0,
    NEXT_DIRECT  = 1'b1
  } next_style_e;
endpackage

// File: rtl/gray_next.sv
module gray_next
  import gray_cnt_pkg::*;
#(
  parameter int unsigned WIDTH      = 4,
  parameter next_style_e NEXT_STYLE = NEXT_DIRECT
) (
  input  logic [WIDTH-1:0] cur_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  generate
    if (NEXT_STYLE == NEXT_CONVERT) begin : g_convert
      logic [WIDTH-1:0] bin, inc;
      always_comb begin
        bin[WIDTH-1] = cur_i[WIDTH-1];
        for (int i = WIDTH-2; i >= 0; i--) bin[i] = bin[i+1] ^ cur_i[i];
        inc   = bin + ONE;
        nxt_o = inc ^ (inc >> 1);
      end
    end else begin : g_direct
      // even parity: flip bit 0; odd: flip bit above lowest one (MSB at top code)
      logic             par;
      logic [WIDTH-1:0] low, flip;
      always_comb begin
        par  = ^cur_i;
        low  = cur_i & (~cur_i + ONE);
        if (!par)            flip = ONE;
        else if (low[WIDTH-1]) flip = low;
        else                 flip = low << 1;
        nxt_o = cur_i ^ flip;
      end
    end
  endgenerate
endmodule

// File: rtl/gray_state.sv
module gray_state #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_data_i,
  input  logic [WIDTH-1:0] inc_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= load_data_i;
    else if (en_i)   q_o <= inc_i;
  end
endmodule

// File: rtl/gray_counter.sv
module gray_counter
  import gray_cnt_pkg::*;
#(
  parameter int unsigned WIDTH      = 4,
  parameter next_style_e NEXT_STYLE = NEXT_DIRECT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_data_i,
  output logic [WIDTH-1:0] count_o
);
  localparam logic [WIDTH-1:0] TOP_CODE = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] inc;

  gray_next #(.WIDTH(WIDTH), .NEXT_STYLE(NEXT_STYLE)) u_next (
    .cur_i(count_o),
    .nxt_o(inc)
  );

  gray_state #(.WIDTH(WIDTH)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .load_i     (load_i),
    .load_data_i(load_data_i),
    .inc_i      (inc),
    .q_o        (count_o)
  );

  AST_ONE_BIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> ($countones(count_o ^ $past(count_o)) == 1)); // R3
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(count_o)); // R4
  AST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_o == $past(load_data_i))); // R5
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i && count_o == TOP_CODE) |=> (count_o == '0)); // R7
endmodule

// File: tb/gray_counter_test.sv
module gray_counter_test;
  import gray_cnt_pkg::*;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       load = 1'b0;
  logic [7:0] ld_data = '0;
  logic [3:0] cnt4;
  logic [7:0] cnt8;
  int         n_checks = 0;
  int         n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // R9: two widths, two next-state styles
  gray_counter #(.WIDTH(4), .NEXT_STYLE(NEXT_DIRECT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .load_i(load),
    .load_data_i(ld_data[3:0]), .count_o(cnt4));
  gray_counter #(.WIDTH(8), .NEXT_STYLE(NEXT_CONVERT)) uut8 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .load_i(load),
    .load_data_i(ld_data), .count_o(cnt8));

  typedef struct {
    logic [3:0] e4;
    logic [7:0] e8;
    logic [3:0] p4;
    logic [7:0] p8;
    bit         step;
    string      tag;
  } item_t;

  item_t q[$];
  int unsigned b4 = 0, b8 = 0;

  function automatic int unsigned g2b(logic [7:0] g);
    logic [7:0] b;
    b[7] = g[7];
    for (int i = 6; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return int'(b);
  endfunction

  function automatic logic [7:0] b2g(int unsigned b);
    logic [7:0] v;
    v = b[7:0];
    return v ^ (v >> 1);
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(bit e, bit l, logic [7:0] d, string tag);
    item_t it;
    @(negedge clk);
    #1;
    it.p4 = b2g(b4)[3:0];
    it.p8 = b2g(b8);
    en = e; load = l; ld_data = d;
    if (l) begin
      b4 = g2b({4'b0, d[3:0]});
      b8 = g2b(d);
    end else if (e) begin
      b4 = (b4 + 1) % 16;
      b8 = (b8 + 1) % 256;
    end
    it.e4 = b2g(b4)[3:0];
    it.e8 = b2g(b8);
    it.step = e && !l;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares one edge after the driver
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check({it.tag, " w4"}, {4'b0, cnt4}, {4'b0, it.e4});
      check({it.tag, " w8"}, cnt8, it.e8);
      if (it.step) begin
        n_checks++;
        if ($countones(cnt4 ^ it.p4) != 1 || $countones(cnt8 ^ it.p8) != 1) begin
          n_fail++;
          $display("FAIL R3: changes %0d/%0d expected 1", $countones(cnt4 ^ it.p4),
                   $countones(cnt8 ^ it.p8));
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    en = 0; load = 0;
    rst_n = 1'b0;
    #1;
    check("R1 w4", {4'b0, cnt4}, 8'h00);
    check("R1 w8", cnt8, 8'h00);
    b4 = 0; b8 = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < 20; i++) begin
      if (b4 == 7)       drive(1, 0, 8'h00, "R8");
      else if (b4 == 15) drive(1, 0, 8'h00, "R7");
      else               drive(1, 0, 8'h00, "R2");
    end
    for (int i = 0; i < 3; i++) drive(0, 0, 8'hFF, "R4");
    drive(0, 1, 8'hA5, "R5");
    drive(0, 0, 8'h00, "R4");
    drive(1, 1, 8'h3C, "R6");
    for (int i = 0; i < 5; i++) drive(1, 0, 8'h00, "R2");
    drive(0, 1, 8'h80, "R5");
    drive(1, 0, 8'h00, "R7");
    drive(0, 1, 8'h08, "R5");
    drive(1, 0, 8'h00, "R7");
    drive(1, 1, 8'h81, "R6");
    drive(0, 0, 8'h00, "R4");
    @(negedge clk);
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 260; i++) drive(1, 0, 8'h00, "R9");
    drive(0, 0, 8'h00, "R4");
    @(negedge clk);
    @(negedge clk);
    // R1: asynchronous clear away from an edge
    #2;
    rst_n = 1'b0;
    #1;
    check("R1 async w4", {4'b0, cnt4}, 8'h00);
    check("R1 async w8", cnt8, 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule